// File: doc/BRIEF.md
# SIMD Lane Copy Execution Unit

This unit executes the lane-copy group of a vector instruction set operating on 128-bit vector registers. One instruction word is presented per cycle with a valid strobe. The unit also receives three operands: the source vector, the current contents of the destination vector, and a 64-bit general-register operand. It then performs one of six operations:

- broadcast of a source lane;
- broadcast of the scalar operand;
- insertion of a source lane into one destination lane;
- insertion of the scalar into one destination lane;
- sign-extending move of a lane to a scalar;
- zero-extending move of a lane to a scalar.

Element width and lane index are both carried in one 5-bit immediate. The position of its lowest set bit selects the width (8, 16, 32 or 64 bits), and the bits above that position give the lane number. Every operation has its own rules about which width and register-width combinations are legal. Illegal encodings raise an undefined-instruction flag instead of a write.

All results are registered and appear one clock after the valid input. A vector result comes with a vector write enable, and a scalar result comes with a scalar write enable.

Top module: `lane_copy_unit`

## Requirements
- R1: The field imm5 is insn[20:16]. The element size code is the position of its lowest set bit among imm5[3:0]: 0 selects 8 bits, 1 selects 16, 2 selects 32 and 3 selects 64. If imm5[3:0] is zero, the instruction is undefined.
- R2: The field op is insn[29], Q is insn[30] and imm4 is insn[14:11]. With op=1 and Q=0 the instruction is undefined. With op=0, any imm4 other than 0, 1, 3, 5 or 7 is undefined.
- R3: Broadcast-lane is op=0 with imm4=0. It replicates source lane imm5>>(size+1) into every destination lane. With Q=0 the upper 64 bits of the result are zero. A 64-bit element with Q=0 is undefined.
- R4: Broadcast-scalar is op=0 with imm4=1. It replicates the low element-width bits of the scalar operand, under the same width and legality rules as R3.
- R5: Insert-lane is op=1 with Q=1, legal for every size. It writes source lane imm4>>size into destination lane imm5>>(size+1), and every other destination lane keeps its prior value.
- R6: Insert-scalar is op=0 with imm4=3 and is legal only with Q=1. It writes the low element-width bits of the scalar operand into destination lane imm5>>(size+1) and preserves all other lanes.
- R7: Signed move is op=0 with imm4=5. It is legal for sizes 0 and 1 with either Q, and for size 2 with Q=1. It sign-extends lane imm5>>(size+1) of the source to 64 bits, and with Q=0 clears the upper 32 bits of the result.
- R8: Unsigned move is op=0 with imm4=7. It is legal for sizes 0 to 2 with Q=0, and for size 3 with Q=1. It zero-extends lane imm5>>(size+1) of the source to 64 bits.
- R9: When the undefined flag is high, neither write enable is high. The two write enables are never high together.
- R10: Exactly one of vector write enable, scalar write enable and undefined flag is high in the cycle after a valid input. None of them is high in the cycle after an idle input or during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction and operands valid this cycle |
| insn | input | 32 | Instruction word |
| src_vec | input | 128 | Source vector operand |
| dst_vec | input | 128 | Current contents of the destination vector |
| scalar_in | input | 64 | General-register operand |
| vec_out | output | 128 | New destination vector |
| vec_we | output | 1 | Vector result write enable |
| scalar_out | output | 64 | Scalar result |
| scalar_we | output | 1 | Scalar result write enable |
| undef | output | 1 | Undefined-instruction flag |

## Verification
The properties assume that in_valid is low while reset is asserted, and that the instruction fields hold steady for the one cycle they are sampled. Past-cycle references are therefore made only from a known idle state. The bench drives inputs only on falling edges and holds in_valid low through reset. It sweeps every combination of op, Q, imm4 and imm5, so every legal and illegal encoding reaches the unit once. Operand patterns change on each instruction so that sign bits and lane contents vary.

// File: rtl/lcu_pkg.sv
package lcu_pkg;
   localparam int SIZE_W = 2;
   localparam int IDX_W  = 4;

   typedef enum logic [2:0] {
      K_NONE,
      K_BCAST_LANE,
      K_BCAST_SCL,
      K_INS_LANE,
      K_INS_SCL,
      K_MOV_S,
      K_MOV_U
   } copy_kind_e;

   typedef struct packed {
      copy_kind_e         kind;
      logic               legal;
      logic [SIZE_W-1:0]  size;
      logic               wide;
      logic [IDX_W-1:0]   lane_idx;
      logic [IDX_W-1:0]   src_idx;
   } copy_dec_t;
endpackage

// File: rtl/lcu_decode.sv
module lcu_decode
   import lcu_pkg::*;
#(
   parameter int INSN_W = 32
) (
   input  logic [INSN_W-1:0] insn,
   output copy_dec_t         dec
);
   logic       q_w;
   logic       op_w;
   logic [3:0] imm4;
   logic [4:0] imm5;
   logic [2:0] shamt;
   logic       size_ok;
   logic       unused_bits;

   assign q_w  = insn[30];
   assign op_w = insn[29];
   assign imm4 = insn[14:11];
   assign imm5 = insn[20:16];
   assign unused_bits = ^{insn[INSN_W-1:31], insn[28:21], insn[15], insn[10:0]};

   always_comb begin
      size_ok = |imm5[3:0];
      casez (imm5[3:0])
         4'b???1: dec.size = 2'd0;
         4'b??10: dec.size = 2'd1;
         4'b?100: dec.size = 2'd2;
         default: dec.size = 2'd3;
      endcase
      shamt        = {1'b0, dec.size} + 3'd1;
      dec.lane_idx = 4'(imm5 >> shamt);
      dec.src_idx  = imm4 >> dec.size;
      dec.wide     = q_w;
      dec.kind     = K_NONE;
      dec.legal    = 1'b0;
      if (op_w) begin
         if (q_w) begin
            dec.kind  = K_INS_LANE;
            dec.legal = 1'b1;
         end
      end else begin
         case (imm4)
            4'd0: begin
               dec.kind  = K_BCAST_LANE;
               dec.legal = !(dec.size == 2'd3 && !q_w);
            end
            4'd1: begin
               dec.kind  = K_BCAST_SCL;
               dec.legal = !(dec.size == 2'd3 && !q_w);
            end
            4'd3: begin
               dec.kind  = K_INS_SCL;
               dec.legal = q_w;
            end
            4'd5: begin
               dec.kind  = K_MOV_S;
               dec.legal = (dec.size < 2'd2) || (dec.size == 2'd2 && q_w);
            end
            4'd7: begin
               dec.kind  = K_MOV_U;
               dec.legal = (dec.size != 2'd3 && !q_w) || (dec.size == 2'd3 && q_w);
            end
            default: begin
               dec.kind  = K_NONE;
               dec.legal = 1'b0;
            end
         endcase
      end
      dec.legal = dec.legal && size_ok;
   end
endmodule

// File: rtl/lcu_lane_pick.sv
module lcu_lane_pick #(
   parameter int VEC_W    = 128,
   parameter int SCL_W    = 64,
   parameter int LANE_MIN = 8,
   localparam int NSIZE   = $clog2(SCL_W / LANE_MIN) + 1,
   localparam int SIZE_W  = $clog2(NSIZE),
   localparam int IDX_W   = $clog2(VEC_W / LANE_MIN)
) (
   input  logic [VEC_W-1:0]  vec,
   input  logic [SIZE_W-1:0] size,
   input  logic [IDX_W-1:0]  idx,
   output logic [SCL_W-1:0]  lane
);
   logic [SCL_W-1:0] cand [NSIZE];

   for (genvar s = 0; s < NSIZE; s++) begin : g_size
      localparam int ES = LANE_MIN << s;
      logic [VEC_W-1:0] shifted;
      assign shifted = vec >> (int'(idx) * ES);
      assign cand[s] = SCL_W'(shifted[ES-1:0]);
   end

   assign lane = cand[size];
endmodule

// File: rtl/lcu_exec.sv
module lcu_exec
   import lcu_pkg::*;
#(
   parameter int VEC_W    = 128,
   parameter int SCL_W    = 64,
   parameter int LANE_MIN = 8,
   localparam int NSIZE   = $clog2(SCL_W / LANE_MIN) + 1
) (
   input  copy_dec_t        dec,
   input  logic [VEC_W-1:0] src_vec,
   input  logic [VEC_W-1:0] dst_vec,
   input  logic [SCL_W-1:0] scl_in,
   output logic [VEC_W-1:0] vec_res,
   output logic [SCL_W-1:0] scl_res,
   output logic             vec_wr,
   output logic             scl_wr
);
   logic [IDX_W-1:0] pick_idx;
   logic [SCL_W-1:0] picked;
   logic [SCL_W-1:0] elem;
   logic             use_scl;
   logic [VEC_W-1:0] rep [NSIZE];
   logic [VEC_W-1:0] ins [NSIZE];
   logic [SCL_W-1:0] sx  [NSIZE];

   assign pick_idx = (dec.kind == K_INS_LANE) ? dec.src_idx : dec.lane_idx;
   assign use_scl  = (dec.kind == K_BCAST_SCL) || (dec.kind == K_INS_SCL);

   lcu_lane_pick #(
      .VEC_W   (VEC_W),
      .SCL_W   (SCL_W),
      .LANE_MIN(LANE_MIN)
   ) i_pick (
      .vec (src_vec),
      .size(dec.size),
      .idx (pick_idx),
      .lane(picked)
   );

   assign elem = use_scl ? scl_in : picked;

   for (genvar s = 0; s < NSIZE; s++) begin : g_size
      localparam int ES = LANE_MIN << s;
      logic [VEC_W-1:0] keep_mask;
      assign rep[s]    = {(VEC_W / ES){elem[ES-1:0]}};
      assign keep_mask = ~(VEC_W'({ES{1'b1}}) << (int'(dec.lane_idx) * ES));
      assign ins[s]    = (dst_vec & keep_mask) |
                         (VEC_W'(elem[ES-1:0]) << (int'(dec.lane_idx) * ES));
      if (ES < SCL_W) begin : g_ext
         assign sx[s] = {{(SCL_W - ES){elem[ES-1]}}, elem[ES-1:0]};
      end else begin : g_full
         assign sx[s] = elem;
      end
   end

   always_comb begin
      vec_res = '0;
      scl_res = '0;
      vec_wr  = 1'b0;
      scl_wr  = 1'b0;
      case (dec.kind)
         K_BCAST_LANE, K_BCAST_SCL: begin
            vec_res = rep[dec.size];
            if (!dec.wide) vec_res[VEC_W-1:VEC_W/2] = '0;
            vec_wr = dec.legal;
         end
         K_INS_LANE, K_INS_SCL: begin
            vec_res = ins[dec.size];
            vec_wr  = dec.legal;
         end
         K_MOV_S: begin
            scl_res = sx[dec.size];
            if (!dec.wide) scl_res[SCL_W-1:SCL_W/2] = '0;
            scl_wr = dec.legal;
         end
         K_MOV_U: begin
            scl_res = picked;
            scl_wr  = dec.legal;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/lane_copy_unit.sv
module lane_copy_unit
   import lcu_pkg::*;
#(
   parameter int VEC_W    = 128,
   parameter int SCL_W    = 64,
   parameter int LANE_MIN = 8,
   parameter int INSN_W   = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [INSN_W-1:0] insn,
   input  logic [VEC_W-1:0]  src_vec,
   input  logic [VEC_W-1:0]  dst_vec,
   input  logic [SCL_W-1:0]  scalar_in,
   output logic [VEC_W-1:0]  vec_out,
   output logic              vec_we,
   output logic [SCL_W-1:0]  scalar_out,
   output logic              scalar_we,
   output logic              undef
);
   if (VEC_W != 2 * SCL_W) begin : g_bad_vec
      $error("vector width must be twice the scalar width");
   end
   if (SCL_W != 8 * LANE_MIN) begin : g_bad_lane
      $error("four element sizes must span the scalar width");
   end
   if (INSN_W != 32) begin : g_bad_insn
      $error("instruction word must be 32 bits");
   end

   copy_dec_t        dec;
   logic [VEC_W-1:0] vec_res;
   logic [SCL_W-1:0] scl_res;
   logic             vec_wr;
   logic             scl_wr;

   lcu_decode #(.INSN_W(INSN_W)) i_decode (
      .insn(insn),
      .dec (dec)
   );

   lcu_exec #(
      .VEC_W   (VEC_W),
      .SCL_W   (SCL_W),
      .LANE_MIN(LANE_MIN)
   ) i_exec (
      .dec    (dec),
      .src_vec(src_vec),
      .dst_vec(dst_vec),
      .scl_in (scalar_in),
      .vec_res(vec_res),
      .scl_res(scl_res),
      .vec_wr (vec_wr),
      .scl_wr (scl_wr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_out    <= '0;
         scalar_out <= '0;
         vec_we     <= 1'b0;
         scalar_we  <= 1'b0;
         undef      <= 1'b0;
      end else begin
         vec_we    <= in_valid && vec_wr;
         scalar_we <= in_valid && scl_wr;
         undef     <= in_valid && !dec.legal;
         if (in_valid) begin
            vec_out    <= vec_res;
            scalar_out <= scl_res;
         end
      end
   end
endmodule

// File: rtl/lcu_checker.sv
module lcu_checker #(
   parameter int HALF_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              q_bit,
   input logic              op_bit,
   input logic [3:0]        imm4,
   input logic [3:0]        imm5_lo,
   input logic [HALF_W-1:0] vec_hi,
   input logic              vec_we,
   input logic              scalar_we,
   input logic              undef
);
   assert_undef_blocks_writes_R9: assert property (@(posedge clk) disable iff (!rst_n)
      undef |-> (!vec_we && !scalar_we));

   assert_single_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({vec_we, scalar_we}));

   assert_one_result_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid) |-> ($countones({vec_we, scalar_we, undef}) == 1));

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(in_valid) |-> (!vec_we && !scalar_we && !undef));

   assert_no_size_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && imm5_lo == 4'd0) |-> undef);

   assert_op1_narrow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && op_bit && !q_bit) |-> undef);

   // covers both broadcast forms (R3 and R4)
   assert_narrow_bcast_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(in_valid && !op_bit && !q_bit && imm4[3:1] == 3'd0) && vec_we) |-> (vec_hi == '0));

   assert_narrow_ins_scl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_valid && !op_bit && !q_bit && imm4 == 4'd3) |-> undef);
endmodule

bind lane_copy_unit lcu_checker #(.HALF_W(VEC_W / 2)) i_lcu_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .q_bit    (insn[30]),
   .op_bit   (insn[29]),
   .imm4     (insn[14:11]),
   .imm5_lo  (insn[19:16]),
   .vec_hi   (vec_out[VEC_W-1:VEC_W/2]),
   .vec_we   (vec_we),
   .scalar_we(scalar_we),
   .undef    (undef)
);

// File: tb/test_lane_copy_unit.sv
`timescale 1ns/1ps
module test_lane_copy_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         in_valid = 1'b0;
   logic [31:0]  insn = '0;
   logic [127:0] src_vec = '0;
   logic [127:0] dst_vec = '0;
   logic [63:0]  scalar_in = '0;
   logic [127:0] vec_out;
   logic         vec_we;
   logic [63:0]  scalar_out;
   logic         scalar_we;
   logic         undef;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   lane_copy_unit i_lane_copy_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
      .src_vec(src_vec), .dst_vec(dst_vec), .scalar_in(scalar_in),
      .vec_out(vec_out), .vec_we(vec_we), .scalar_out(scalar_out),
      .scalar_we(scalar_we), .undef(undef)
   );

   task automatic model(input bit q, input bit op, input bit [3:0] imm4, input bit [4:0] imm5,
                        input bit [127:0] src, input bit [127:0] dst, input bit [63:0] scl,
                        output bit ud, output bit vwe, output bit swe,
                        output bit [127:0] ev, output bit [63:0] es, output string tag);
      int sz = -1;
      int esize, lidx, sidx, lanes;
      bit [63:0] e;
      ud = 0; vwe = 0; swe = 0; ev = '0; es = '0; e = '0;
      for (int b = 0; b < 4; b++) if (sz < 0 && imm5[b]) sz = b;
      if (sz < 0) begin ud = 1; tag = "R1"; return; end
      esize = 8 << sz;
      lidx  = int'(imm5) >> (sz + 1);
      if (op) begin
         tag = q ? "R5" : "R2";
         if (!q) begin ud = 1; return; end
         sidx = int'(imm4) >> sz;
         ev = dst;
         for (int b = 0; b < esize; b++) ev[lidx*esize+b] = src[sidx*esize+b];
         vwe = 1;
         return;
      end
      case (imm4)
         4'd0, 4'd1: begin
            tag = (imm4 == 0) ? "R3" : "R4";
            if (sz == 3 && !q) begin ud = 1; return; end
            for (int b = 0; b < esize; b++) e[b] = (imm4 == 0) ? src[lidx*esize+b] : scl[b];
            lanes = (q ? 128 : 64) / esize;
            for (int l = 0; l < lanes; l++)
               for (int b = 0; b < esize; b++) ev[l*esize+b] = e[b];
            vwe = 1;
         end
         4'd3: begin
            tag = "R6";
            if (!q) begin ud = 1; return; end
            ev = dst;
            for (int b = 0; b < esize; b++) ev[lidx*esize+b] = scl[b];
            vwe = 1;
         end
         4'd5: begin
            tag = "R7";
            if (!(sz <= 1 || (sz == 2 && q))) begin ud = 1; return; end
            for (int b = 0; b < 64; b++)
               es[b] = (b < esize) ? src[lidx*esize+b] : src[lidx*esize+esize-1];
            if (!q) es[63:32] = '0;
            swe = 1;
         end
         4'd7: begin
            tag = "R8";
            if (!((sz <= 2 && !q) || (sz == 3 && q))) begin ud = 1; return; end
            for (int b = 0; b < esize; b++) es[b] = src[lidx*esize+b];
            swe = 1;
         end
         default: begin ud = 1; tag = "R2"; end
      endcase
   endtask

   initial begin
      bit ud, vwe, swe;
      bit [127:0] ev;
      bit [63:0] es;
      string tag;
      int n = 0;
      repeat (3) @(negedge clk);
      checks++;
      if (vec_we || scalar_we || undef) begin
         errors++;
         $display("FAIL R10 reset: we=%b/%b undef=%b expected 0/0/0", vec_we, scalar_we, undef);
      end
      rst_n = 1'b1;
      for (int op = 0; op < 2; op++)
         for (int q = 0; q < 2; q++)
            for (int i4 = 0; i4 < 16; i4++)
               for (int i5 = 0; i5 < 32; i5++) begin
                  @(negedge clk);
                  for (int k = 0; k < 16; k++) begin
                     src_vec[k*8 +: 8] = 8'(k * 17 + n * 3 + 8'h81);
                     dst_vec[k*8 +: 8] = 8'(k * 29 + n * 5 + 3);
                  end
                  for (int k = 0; k < 8; k++) scalar_in[k*8 +: 8] = 8'(k * 37 + n * 7 + 8'hC5);
                  insn = {1'b0, 1'(q), 1'(op), 8'b01110000, 5'(i5), 1'b0, 4'(i4), 1'b1, 5'd7, 5'd3};
                  in_valid = 1'b1;
                  model(1'(q), 1'(op), 4'(i4), 5'(i5), src_vec, dst_vec, scalar_in,
                        ud, vwe, swe, ev, es, tag);
                  @(negedge clk);
                  in_valid = 1'b0;
                  checks++;
                  if (undef !== ud || vec_we !== vwe || scalar_we !== swe ||
                      (vwe && vec_out !== ev) || (swe && scalar_out !== es)) begin
                     errors++;
                     $display("FAIL %s op=%0d q=%0d imm4=%0d imm5=%0d: ud/vwe/swe=%b%b%b vec=%h scl=%h expected %b%b%b vec=%h scl=%h",
                              tag, op, q, i4, i5, undef, vec_we, scalar_we, vec_out, scalar_out,
                              ud, vwe, swe, ev, es);
                  end
                  if ((n % 16) == 0) begin
                     @(negedge clk);
                     checks++;
                     if (vec_we || scalar_we || undef) begin
                        errors++;
                        $display("FAIL R10 idle: we=%b/%b undef=%b expected 0/0/0", vec_we, scalar_we, undef);
                     end
                  end
                  n++;
               end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule